// File: doc/BRIEF.md
# Dual-Direction Priority Encoder

This block takes a small vector of request lines and reports the position of one active line as a binary index, together with a flag that shows whether any line is active. A single direction input picks the priority order. With the input low, the highest-numbered active line wins. With the input high, the lowest-numbered active line wins. The block is purely combinational and has no clock.

The design uses a single fixed-priority core that always favours the highest-numbered line. To serve the lowest-first order, the request vector is mirrored before it enters the core. The resulting index is then mapped back by subtracting it from the top position. A small control module turns the direction input into two steering strobes. One strobe selects the mirrored input and the other selects the mapped-back index. When no request is active, the index output is forced to zero, so it never carries a meaningless value.

Top module: `dual_prio_enc`

## Requirements
- R1: With `lsbMode` = 0 and at least one request set, `idxOut` equals the bit position of the highest set bit of `reqIn` (bit 0 is position 0).
- R2: With `lsbMode` = 1 and at least one request set, `idxOut` equals the bit position of the lowest set bit of `reqIn`.
- R3: `anyValid` is 1 exactly when at least one bit of `reqIn` is 1.
- R4: When `reqIn` is all zeros, `idxOut` is 2'b00 in both modes.
- R5: For `reqIn` = 4'b1111, `idxOut` is 3 with `lsbMode` = 0 and 0 with `lsbMode` = 1.
- R6: When exactly one bit of `reqIn` is set, `idxOut` gives that bit's position whatever the value of `lsbMode`.
- R7: For any fixed `reqIn`, toggling `lsbMode` leaves `anyValid` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reqIn | input | 4 | Request lines, bit 0 lowest position |
| lsbMode | input | 1 | 0: highest set bit wins; 1: lowest set bit wins |
| idxOut | output | 2 | Binary position of the winning request |
| anyValid | output | 1 | High when any request line is set |

## Verification
Two functions can act on the same input pattern: the mirror-and-map path chosen by the direction input, and the forced-zero rule for an empty request vector. Both meet when `reqIn` is zero with `lsbMode` high. In that case the mapping would turn a zero core index into 3 if the forcing were missing. The bench drives every request pattern in both modes, including the empty and full patterns. It also toggles the direction input with the requests held, to show that the index moves while the flag stays put. Each result is judged against a reference model in the bench that scans the bits directly.

// File: rtl/dpe_pkg.sv
package dpe_pkg;

  // Steering strobes from control to datapath
  typedef struct packed {
    logic mirrorIn;   // feed the core with the bit-reversed request vector
    logic remapIdx;   // map the core index i back to (top - i)
  } dpeSteer_t;

endpackage

// File: rtl/dpe_prio_core.sv
// Fixed-priority core: the highest-numbered set bit wins.
module dpe_prio_core #(
  parameter int REQ_W = 4,
  localparam int IDX_W = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
  input  logic [REQ_W-1:0] req,
  output logic [IDX_W-1:0] idx,
  output logic             hit
);

  always_comb begin
    idx = '0;
    for (int i = 0; i < REQ_W; i++) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign hit = |req;

endmodule

// File: rtl/dpe_ctrl.sv
// Control: turns the direction input into datapath strobes.
module dpe_ctrl
  import dpe_pkg::*;
(
  input  logic       lsbMode,
  output dpeSteer_t  steer
);

  always_comb begin
    steer          = '0;
    steer.mirrorIn = lsbMode;
    steer.remapIdx = lsbMode;
  end

endmodule

// File: rtl/dpe_datapath.sv
// Datapath: optional mirror, fixed core, optional index remap, zero forcing.
module dpe_datapath
  import dpe_pkg::*;
#(
  parameter int REQ_W = 4,
  localparam int IDX_W = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
  input  logic [REQ_W-1:0] reqIn,
  input  dpeSteer_t        steer,
  output logic [IDX_W-1:0] idxOut,
  output logic             anyValid
);

  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(REQ_W - 1);

  logic [REQ_W-1:0] reqRev;
  logic [REQ_W-1:0] coreReq;
  logic [IDX_W-1:0] coreIdx;
  logic             coreHit;
  logic [IDX_W-1:0] mappedIdx;

  for (genvar g = 0; g < REQ_W; g++) begin : g_rev
    assign reqRev[g] = reqIn[REQ_W-1-g];
  end

  assign coreReq = steer.mirrorIn ? reqRev : reqIn;

  dpe_prio_core #(.REQ_W(REQ_W)) u_core (
    .req (coreReq),
    .idx (coreIdx),
    .hit (coreHit)
  );

  assign mappedIdx = steer.remapIdx ? (TOP_IDX - coreIdx) : coreIdx;
  assign idxOut    = coreHit ? mappedIdx : '0;
  assign anyValid  = coreHit;

endmodule

// File: rtl/dual_prio_enc.sv
// Thin top: control plus datapath.
module dual_prio_enc
  import dpe_pkg::*;
#(
  parameter int REQ_W = 4,
  localparam int IDX_W = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
  input  logic [REQ_W-1:0] reqIn,
  input  logic             lsbMode,
  output logic [IDX_W-1:0] idxOut,
  output logic             anyValid
);

  dpeSteer_t steer;

  dpe_ctrl u_ctrl (
    .lsbMode (lsbMode),
    .steer   (steer)
  );

  dpe_datapath #(.REQ_W(REQ_W)) u_dp (
    .reqIn    (reqIn),
    .steer    (steer),
    .idxOut   (idxOut),
    .anyValid (anyValid)
  );

endmodule

// File: rtl/dpe_chk.sv
// Checker bound to the top; combinational properties on the ports.
module dpe_chk #(
  parameter int REQ_W = 4,
  localparam int IDX_W = (REQ_W > 1) ? $clog2(REQ_W) : 1
) (
  input logic [REQ_W-1:0] reqIn,
  input logic             lsbMode,
  input logic [IDX_W-1:0] idxOut,
  input logic             anyValid
);

  logic known;
  assign known = !$isunknown({reqIn, lsbMode, idxOut, anyValid});

  always_comb begin
    if (known) begin
      // R3
      valid_flag_chk: assert (anyValid == (reqIn != '0));
      // R4
      empty_zero_chk: assert (anyValid || idxOut == '0);
      // R1
      hi_sel_chk: assert (!anyValid || lsbMode ||
                          ((reqIn >> idxOut) == REQ_W'(1)));
      // R2
      lo_sel_chk: assert (!anyValid || !lsbMode ||
                          (reqIn[idxOut] &&
                           ((reqIn & ((REQ_W'(1) << idxOut) - REQ_W'(1))) == '0)));
      // R6
      single_bit_chk: assert ($countones(reqIn) != 1 || reqIn[idxOut]);
    end
  end

endmodule

bind dual_prio_enc dpe_chk #(.REQ_W(REQ_W)) u_chk (
  .reqIn    (reqIn),
  .lsbMode  (lsbMode),
  .idxOut   (idxOut),
  .anyValid (anyValid)
);

// File: tb/dual_prio_enc_tb.sv
module dual_prio_enc_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] reqIn = '0;
  logic       lsbMode = 1'b0;
  logic [1:0] idxOut;
  logic       anyValid;
  int         nChecks = 0;
  int         nFails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dual_prio_enc u_dut (
    .reqIn    (reqIn),
    .lsbMode  (lsbMode),
    .idxOut   (idxOut),
    .anyValid (anyValid)
  );

  function automatic logic [1:0] modelIdx(input logic [3:0] r, input logic m);
    logic [1:0] res = 2'd0;
    if (m) begin
      for (int i = 3; i >= 0; i--) if (r[i]) res = 2'(i);
    end else begin
      for (int i = 0; i < 4; i++) if (r[i]) res = 2'(i);
    end
    return res;
  endfunction

  task automatic checkVal(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s req=%b mode=%b actual=%0d expected=%0d",
               tag, reqIn, lsbMode, act, exp);
    end
  endtask

  // drive at posedge, sample at negedge
  task automatic applyAndCheck(input logic [3:0] r, input logic m);
    @(posedge clk);
    reqIn = r;
    lsbMode = m;
    @(negedge clk);
    checkVal("R3 valid", int'(anyValid), int'(r != 4'd0));
    if (r == 4'd0)
      checkVal("R4 empty index", int'(idxOut), 0);
    else if ($countones(r) == 1)
      checkVal("R6 single bit", int'(idxOut), int'(modelIdx(r, m)));
    else if (m)
      checkVal("R2 lowest", int'(idxOut), int'(modelIdx(r, 1'b1)));
    else
      checkVal("R1 highest", int'(idxOut), int'(modelIdx(r, 1'b0)));
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [3:0] r;
    logic       v0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // reset-state check with idle inputs
    checkVal("R4 reset idle index", int'(idxOut), 0);
    checkVal("R3 reset idle valid", int'(anyValid), 0);
    rstN = 1'b1;

    // directed corners
    applyAndCheck(4'b0000, 1'b1);
    checkVal("R4 empty lsb mode", int'(idxOut), 0);
    applyAndCheck(4'b1111, 1'b0);
    checkVal("R5 full msb", int'(idxOut), 3);
    applyAndCheck(4'b1111, 1'b1);
    checkVal("R5 full lsb", int'(idxOut), 0);
    applyAndCheck(4'b0100, 1'b0);
    checkVal("R6 single msb", int'(idxOut), 2);
    applyAndCheck(4'b0100, 1'b1);
    checkVal("R6 single lsb", int'(idxOut), 2);

    // exhaustive sweep
    for (int k = 0; k < 32; k++) applyAndCheck(4'(k), 1'(k >> 4));

    // R7: toggle mode with requests held
    for (int k = 0; k < 16; k++) begin
      applyAndCheck(4'(k), 1'b0);
      v0 = anyValid;
      applyAndCheck(4'(k), 1'b1);
      checkVal("R7 flag mode-independent", int'(anyValid), int'(v0));
    end

    // random mix
    for (int k = 0; k < 60; k++) begin
      r = 4'($urandom);
      applyAndCheck(r, 1'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule